// File: doc/BRIEF.md
# SDRAM Mode Register Programmer

This block watches the command pins of a synchronous DRAM command bus and keeps a shadow copy of the device's two configuration registers. When a register-set command is sampled (chip select, row strobe, column strobe and write enable all low on a rising clock edge), the 13 address bits and 2 bank bits are taken as the operand. Bank code 00 targets the normal register and bank code 10 targets the extended register. The stored settings are presented as decoded values: the burst length as a beat count, the burst ordering, the read latency in clocks, the single-beat write switch, the partial-array refresh size and the output driver strength.

A controller or a bus monitor uses the outputs to shape its bursts and its read-data capture. The block also checks the command stream and raises a one-clock violation pulse for two mistakes. The first is a register write while any bank is open, reported through a single all-banks-idle input. The second is any command issued inside the settling window that follows an accepted register write. A write is discarded when it is unsafe or when its operand is malformed, so the shadow registers only hold settings the device would accept.

Top module: `sdr_modereg_prog`

## Requirements
- R1: After synchronous reset the outputs are: burst length 1, sequential ordering (`burst_interleave`=0), read latency 3, `single_write`=0, `refresh_size`=0 (full array), `drive_strength`=0 (full) and `violation`=0.
- R2: An accepted write to the normal register (bank 00) sets the burst length from operand bits 2:0, visible on the clock after the command edge. The codes are 000→1, 001→2, 010→4, 011→8 and 111→full page (PAGE_LEN, default 1024).
- R3: In the same write, operand bit 3 sets `burst_interleave` (1 = interleaved). Operand bits 6:4 set `rd_latency`, with the codes 001→1, 010→2 and 011→3.
- R4: In the same write, operand bit 9 sets `single_write`, so that reads burst and writes are one beat.
- R5: An accepted write to the extended register (bank 10) sets `refresh_size` from bits 2:0 (000→0 full, 001→1 half, 010→2 quarter). It sets `drive_strength` from bits 6:5 (00→0 full, 01→1 half, 10→2 quarter, 11→3 eighth).
- R6: A register-set command with bank code 01 or 11 changes neither register.
- R7: A write is discarded, and both registers keep their contents, if its operand holds a reserved field code or a nonzero reserved bit. For the normal register the reserved codes are burst codes 100–110 and latency codes 000 and 100–111, and the reserved bits are 8:7 and 12:10. For the extended register the reserved codes are refresh codes 011–111, and the reserved bits are 4:3 and 12:7.
- R8: A register-set command sampled while `banks_idle` is 0 is discarded, and `violation` is 1 for exactly the following clock.
- R9: After an accepted register write at edge T, any non-NOP command at edge T+1 raises `violation` for the following clock, and a register write at T+1 is discarded. A command at edge T+2 is accepted normally.
- R10: A deselect (`cs_n`=1) or a NOP (`cs_n`=0 with `ras_n`, `cas_n` and `we_n` all 1) never raises `violation` and never changes a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Address bus, register operand during a register-set command |
| bank | input | 2 | Bank bits, register select during a register-set command |
| banks_idle | input | 1 | 1 when every bank is precharged |
| burst_len | output | 11 | Burst length in beats |
| burst_interleave | output | 1 | 1 = interleaved ordering, 0 = sequential |
| rd_latency | output | 2 | Read latency in clocks (1..3) |
| single_write | output | 1 | 1 = writes are single beat |
| refresh_size | output | 2 | Self-refresh array portion: 0 full, 1 half, 2 quarter |
| drive_strength | output | 2 | Driver strength: 0 full, 1 half, 2 quarter, 3 eighth |
| violation | output | 1 | One-clock pulse on an illegal command |

## Verification
The bench targets the edge of the settling window. A window that is one clock too long would reject the legal command at T+2 and flag it, and a window that is too short would let a write at T+1 through without a pulse. It writes each reserved code and each reserved bit on its own. A decoder that is too loose would then change a register on malformed data. Bank codes 01 and 11 are driven with operands that are otherwise valid, to catch select logic that looks at only one bank bit. Writes with banks open, and NOPs placed inside the window, check that the violation pulse fires on the right cause and lasts exactly one clock.

// File: rtl/sdr_mr_pkg.sv
// Package: shared constants and types for the mode register programmer.
// Assumes the operand is 13 address bits plus 2 bank bits.
package sdr_mr_pkg;

    localparam int OP_W   = 13;
    localparam int BANK_W = 2;

    // Register space selected by the bank bits during a register-set command
    localparam logic [BANK_W-1:0] SPACE_NORMAL   = 2'b00;
    localparam logic [BANK_W-1:0] SPACE_EXTENDED = 2'b10;

    // Burst length codes that the device accepts
    typedef enum logic [2:0] {
        BL_ONE  = 3'b000,
        BL_TWO  = 3'b001,
        BL_FOUR = 3'b010,
        BL_EIGHT= 3'b011,
        BL_PAGE = 3'b111
    } bl_code_e;

    // Portion of the array kept alive in self refresh
    typedef enum logic [1:0] {
        RF_FULL    = 2'd0,
        RF_HALF    = 2'd1,
        RF_QUARTER = 2'd2
    } refresh_e;

    // Decoded view of one sampled command
    typedef struct packed {
        logic set_reg;   // register-set command
        logic real_cmd;  // anything other than deselect or NOP
    } cmd_t;

endpackage

// File: rtl/sdr_mr_cmd_dec.sv
// Command decoder: turns the four sampled strobes into a register-set flag
// and a "real command" flag. Purely combinational; assumes the strobes are
// already synchronous to clk.
module sdr_mr_cmd_dec
    import sdr_mr_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_t cmd
);

    // Decode chip select and the strobe pattern
    always_comb begin
        cmd.set_reg  = !cs_n && !ras_n && !cas_n && !we_n;
        cmd.real_cmd = !cs_n && !(ras_n && cas_n && we_n);
    end

endmodule

// File: rtl/sdr_mr_guard.sv
// Command guard: runs the settling window after an accepted register write
// and produces the one-clock violation pulse. Assumes MRD_CLKS >= 1; the
// window covers the MRD_CLKS-1 edges after the write.
module sdr_mr_guard #(
    parameter int MRD_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_reg,
    input  logic real_cmd,
    input  logic banks_idle,
    input  logic wr_done,
    output logic lock_active,
    output logic violation
);

    localparam int LW = (MRD_CLKS > 1) ? $clog2(MRD_CLKS) + 1 : 1;
    localparam logic [LW-1:0] LOAD = LW'(MRD_CLKS - 1);

    logic [LW-1:0] lock_cnt;

    assign lock_active = (lock_cnt != '0);

    // Count down the settling window, reload on every accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_cnt <= '0;
        else if (wr_done)
            lock_cnt <= LOAD;
        else if (lock_active)
            lock_cnt <= lock_cnt - 1'b1;
    end

    // Flag a write with banks open or any command inside the window
    always_ff @(posedge clk) begin
        if (!rst_n)
            violation <= 1'b0;
        else
            violation <= (set_reg && !banks_idle) || (real_cmd && lock_active);
    end

    p_open_bank_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_reg && !banks_idle) |=> violation);

    p_window_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (real_cmd && lock_active) |=> violation);

    p_no_write_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |-> !wr_done);

    p_quiet_on_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!real_cmd) |=> !violation);

endmodule

// File: rtl/sdr_mr_norm_reg.sv
// Normal mode register: checks the operand for reserved codes and bits,
// stores burst length, ordering, read latency and the single-beat write bit,
// and presents them decoded. Assumes wr_req is already gated by bank state,
// the settling window and the register select.
module sdr_mr_norm_reg
    import sdr_mr_pkg::*;
#(
    parameter int PAGE_LEN = 1024,
    parameter int BLW      = $clog2(PAGE_LEN) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic [OP_W-1:0] op,
    output logic            op_ok,
    output logic [BLW-1:0]  burst_len,
    output logic            burst_interleave,
    output logic [1:0]      rd_latency,
    output logic            single_write
);

    logic [2:0] bl_code;
    logic [1:0] lat_q;
    logic       bt_q;
    logic       sw_q;
    logic       bl_legal;
    logic       lat_legal;
    logic       rsv_zero;

    // Judge the operand: legal field codes and clear reserved bits
    always_comb begin
        unique case (op[2:0])
            BL_ONE, BL_TWO, BL_FOUR, BL_EIGHT, BL_PAGE: bl_legal = 1'b1;
            default:                                    bl_legal = 1'b0;
        endcase
        lat_legal = (op[6:4] == 3'd1) || (op[6:4] == 3'd2) || (op[6:4] == 3'd3);
        rsv_zero  = (op[8:7] == 2'b00) && (op[12:10] == 3'b000);
        op_ok     = bl_legal && lat_legal && rsv_zero;
    end

    // Store the fields on an accepted, well-formed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bl_code <= BL_ONE;
            bt_q    <= 1'b0;
            lat_q   <= 2'd3;
            sw_q    <= 1'b0;
        end else if (wr_req && op_ok) begin
            bl_code <= op[2:0];
            bt_q    <= op[3];
            lat_q   <= op[5:4];
            sw_q    <= op[9];
        end
    end

    // Expand the stored burst code into a beat count
    always_comb begin
        if (bl_code == BL_PAGE)
            burst_len = BLW'(PAGE_LEN);
        else
            burst_len = BLW'(1) << bl_code;
    end

    assign burst_interleave = bt_q;
    assign rd_latency       = lat_q;
    assign single_write     = sw_q;

    p_hold_without_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && op_ok) |=> ($stable(burst_len) && $stable(burst_interleave)
                                && $stable(rd_latency) && $stable(single_write)));

    p_bl_single_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(burst_len) == 1);

    p_latency_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_latency != 2'd0);

    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && op_ok) |=> (single_write == $past(op[9])));

endmodule

// File: rtl/sdr_mr_ext_reg.sv
// Extended mode register: checks the operand for reserved codes and bits,
// stores the refreshed array portion and the driver strength. Assumes
// wr_req is already gated by bank state, the window and the register select.
module sdr_mr_ext_reg
    import sdr_mr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic [OP_W-1:0] op,
    output logic            op_ok,
    output logic [1:0]      refresh_size,
    output logic [1:0]      drive_strength
);

    refresh_e   rf_q;
    logic [1:0] ds_q;

    // Judge the operand: refresh code in range and reserved bits clear
    always_comb begin
        op_ok = (op[2:0] <= 3'd2) && (op[4:3] == 2'b00) && (op[12:7] == 6'd0);
    end

    // Store the fields on an accepted, well-formed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= RF_FULL;
            ds_q <= 2'd0;
        end else if (wr_req && op_ok) begin
            rf_q <= refresh_e'(op[1:0]);
            ds_q <= op[6:5];
        end
    end

    assign refresh_size   = rf_q;
    assign drive_strength = ds_q;

    p_refresh_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_size != 2'd3);

    p_ext_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && op_ok) |=> ($stable(refresh_size) && $stable(drive_strength)));

endmodule

// File: rtl/sdr_modereg_prog.sv
// Top: decodes the command bus, gates register writes on bank state and the
// settling window, routes the operand to the normal or extended register by
// bank code, and reports violations. Assumes all inputs are synchronous.
module sdr_modereg_prog
    import sdr_mr_pkg::*;
#(
    parameter int PAGE_LEN = 1024,
    parameter int MRD_CLKS = 2,
    parameter int BLW      = $clog2(PAGE_LEN) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [OP_W-1:0]   addr,
    input  logic [BANK_W-1:0] bank,
    input  logic              banks_idle,
    output logic [BLW-1:0]    burst_len,
    output logic              burst_interleave,
    output logic [1:0]        rd_latency,
    output logic              single_write,
    output logic [1:0]        refresh_size,
    output logic [1:0]        drive_strength,
    output logic              violation
);

    cmd_t cmd;
    logic lock_active;
    logic wr_gate;
    logic norm_req;
    logic ext_req;
    logic norm_ok;
    logic ext_ok;
    logic wr_done;

    sdr_mr_cmd_dec u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    // Route a safe register-set command to the selected register space
    always_comb begin
        wr_gate  = cmd.set_reg && banks_idle && !lock_active;
        norm_req = wr_gate && (bank == SPACE_NORMAL);
        ext_req  = wr_gate && (bank == SPACE_EXTENDED);
        wr_done  = (norm_req && norm_ok) || (ext_req && ext_ok);
    end

    sdr_mr_guard #(.MRD_CLKS(MRD_CLKS)) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_reg     (cmd.set_reg),
        .real_cmd    (cmd.real_cmd),
        .banks_idle  (banks_idle),
        .wr_done     (wr_done),
        .lock_active (lock_active),
        .violation   (violation)
    );

    sdr_mr_norm_reg #(.PAGE_LEN(PAGE_LEN), .BLW(BLW)) u_norm (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_req           (norm_req),
        .op               (addr),
        .op_ok            (norm_ok),
        .burst_len        (burst_len),
        .burst_interleave (burst_interleave),
        .rd_latency       (rd_latency),
        .single_write     (single_write)
    );

    sdr_mr_ext_reg u_ext (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_req         (ext_req),
        .op             (addr),
        .op_ok          (ext_ok),
        .refresh_size   (refresh_size),
        .drive_strength (drive_strength)
    );

    p_reserved_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.set_reg && bank[0]) |=> ($stable(burst_len) && $stable(rd_latency)
            && $stable(burst_interleave) && $stable(single_write)
            && $stable(refresh_size) && $stable(drive_strength)));

    p_open_bank_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !banks_idle |-> !wr_done);

    p_ext_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && ext_ok) |=> (drive_strength == $past(addr[6:5])));

endmodule

// File: tb/sim_sdr_modereg_prog.sv
module sim_sdr_modereg_prog;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [12:0] addr;
    logic [1:0]  bank;
    logic        banks_idle;
    logic [10:0] burst_len;
    logic        burst_interleave;
    logic [1:0]  rd_latency;
    logic        single_write;
    logic [1:0]  refresh_size;
    logic [1:0]  drive_strength;
    logic        violation;

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model of the registers
    int m_bl = 1, m_bt = 0, m_cl = 3, m_sw = 0, m_rf = 0, m_ds = 0, m_lock = 0, m_viol = 0;

    always #10 clk = ~clk;

    sdr_modereg_prog u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr(addr), .bank(bank), .banks_idle(banks_idle),
        .burst_len(burst_len), .burst_interleave(burst_interleave),
        .rd_latency(rd_latency), .single_write(single_write),
        .refresh_size(refresh_size), .drive_strength(drive_strength),
        .violation(violation)
    );

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "burst_len R2", int'(burst_len), m_bl);
        check(tag, "interleave R3", int'(burst_interleave), m_bt);
        check(tag, "latency R3", int'(rd_latency), m_cl);
        check(tag, "single_write R4", int'(single_write), m_sw);
        check(tag, "refresh R5", int'(refresh_size), m_rf);
        check(tag, "drive R5", int'(drive_strength), m_ds);
        check(tag, "violation R8/R9", int'(violation), m_viol);
    endtask

    function automatic int bl_beats(int code);
        if (code == 7) return 1024;
        return 1 << code;
    endfunction

    // Apply one command at the falling edge, advance one clock, compare
    task automatic step(string tag, bit c, bit r, bit ca, bit w,
                        logic [12:0] a, logic [1:0] b, bit idle);
        bit mrs, real_c, locked, ok, nv, ev;
        int blc, clc;
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; addr = a; bank = b; banks_idle = idle;
        mrs    = !c && !r && !ca && !w;
        real_c = !c && !(r && ca && w);
        locked = (m_lock != 0);
        ok     = mrs && idle && !locked;
        blc    = int'(a[2:0]);
        clc    = int'(a[6:4]);
        nv = ok && (b == 2'b00) && (a[12:10] == 0) && (a[8:7] == 0)
             && (blc <= 3 || blc == 7) && (clc >= 1 && clc <= 3);
        ev = ok && (b == 2'b10) && (a[12:7] == 0) && (a[4:3] == 0) && (a[2:0] <= 2);
        m_viol = ((mrs && !idle) || (real_c && locked)) ? 1 : 0;
        if (nv) begin
            m_bl = bl_beats(blc); m_bt = int'(a[3]); m_cl = clc; m_sw = int'(a[9]);
        end
        if (ev) begin
            m_rf = int'(a[2:0]); m_ds = int'(a[6:5]);
        end
        if (nv || ev) m_lock = 1;
        else if (m_lock != 0) m_lock = m_lock - 1;
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic nop(string tag);
        step(tag, 1'b0, 1'b1, 1'b1, 1'b1, 13'h1fff, 2'b11, 1'b1);
    endtask

    task automatic set_norm(string tag, int wbl, int cl, int bt, int bl);
        step(tag, 0, 0, 0, 0, {3'b000, 1'(wbl), 2'b00, 3'(cl), 1'(bt), 3'(bl)}, 2'b00, 1'b1);
    endtask

    task automatic set_ext(string tag, int ds, int rf);
        step(tag, 0, 0, 0, 0, {6'd0, 2'(ds), 2'b00, 3'(rf)}, 2'b10, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        addr = '0; bank = '0; banks_idle = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1 reset");

        // R2 every legal burst code, with two settle clocks between writes
        foreach (bl_list[i]) begin end
        for (int k = 0; k < 5; k++) begin
            int codes[5] = '{0, 1, 2, 3, 7};
            set_norm("R2 burst", 0, 2, 0, codes[k]);
            nop("R2 settle");
        end
        // R3 ordering and every legal latency
        for (int k = 1; k <= 3; k++) begin
            set_norm("R3 latency", 0, k, k & 1, 2);
            nop("R3 settle");
        end
        // R4 single-beat write on and off
        set_norm("R4 on", 1, 3, 0, 3);  nop("R4 settle");
        set_norm("R4 off", 0, 3, 0, 3); nop("R4 settle");
        // R5 every refresh and strength code
        for (int k = 0; k < 4; k++) begin
            set_ext("R5 ext", k, k % 3);
            nop("R5 settle");
        end
        // R6 reserved spaces with otherwise valid operands
        step("R6 space01", 0, 0, 0, 0, 13'h0023, 2'b01, 1'b1);
        step("R6 space11", 0, 0, 0, 0, 13'h0041, 2'b11, 1'b1);
        // R7 reserved codes and reserved bits
        step("R7 bl100", 0, 0, 0, 0, 13'h0024, 2'b00, 1'b1);
        step("R7 cl000", 0, 0, 0, 0, 13'h0002, 2'b00, 1'b1);
        step("R7 cl100", 0, 0, 0, 0, 13'h0042, 2'b00, 1'b1);
        step("R7 bit7", 0, 0, 0, 0, 13'h00a2, 2'b00, 1'b1);
        step("R7 bit12", 0, 0, 0, 0, 13'h1022, 2'b00, 1'b1);
        step("R7 rf011", 0, 0, 0, 0, 13'h0003, 2'b10, 1'b1);
        step("R7 ext bit3", 0, 0, 0, 0, 13'h0008, 2'b10, 1'b1);
        step("R7 ext bit9", 0, 0, 0, 0, 13'h0200, 2'b10, 1'b1);
        // R8 banks open
        step("R8 open", 0, 0, 0, 0, 13'h0031, 2'b00, 1'b0);
        nop("R8 pulse ends");
        // R9 command right after a write, then a legal one at T+2
        set_norm("R9 write", 0, 2, 1, 1);
        step("R9 in window", 0, 0, 0, 0, 13'h0033, 2'b00, 1'b1);
        set_norm("R9 at T+2", 0, 1, 0, 3);
        step("R9 read in window", 0, 1, 0, 1, 13'h0000, 2'b00, 1'b1);
        nop("R9 clear");
        // R10 NOP and deselect right after a write
        set_ext("R10 write", 1, 1);
        nop("R10 nop in window");
        set_ext("R10 write2", 2, 2);
        step("R10 deselect", 1, 0, 0, 0, 13'h0000, 2'b00, 1'b0);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int pick = int'($urandom_range(0, 99));
            bit c, r, ca, w;
            logic [12:0] a;
            if (pick < 40)      {c, r, ca, w} = 4'b0000;
            else if (pick < 60) {c, r, ca, w} = 4'b0111;
            else if (pick < 70) {c, r, ca, w} = {1'b1, 3'($urandom)};
            else                {c, r, ca, w} = 4'($urandom);
            if ($urandom_range(0, 1) == 0)
                a = {3'b000, 1'($urandom), 2'b00, 3'($urandom_range(1, 3)),
                     1'($urandom), 3'($urandom_range(0, 3))};
            else
                a = 13'($urandom);
            step("R2 random", c, r, ca, w, a, 2'($urandom),
                 ($urandom_range(0, 99) < 85));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    int bl_list[1] = '{0};

endmodule